// File: doc/BRIEF.md
# Page-Mode Asynchronous Read Sequencer

This block reads from an external asynchronous memory that can serve burst reads out of an open page. An internal client presents a byte address with a valid/ready handshake. The sequencer drives the external address bus, an active-low chip select and an active-low read strobe. It captures the returned data on the final strobe cycle and hands it back with a one-cycle acknowledge.

The sequencer remembers the page it touched last. A read that lands in that page is served with a short, separately programmed strobe time. A read that opens a different page first drops chip select for a cycle and then uses the longer first-access time. Page length, page-mode enable, device width (8 or 16 bits) and both strobe times are static configuration inputs, which are only changed while the block is idle.

Top module: `pgrd_seq`

## Requirements
- R1: After reset, req_ready is 1, mem_cs_n is 1, mem_rd_n is 1 and rsp_ack is 0.
- R2: cfg_page_sz selects the page length: 0 gives 4 bytes, 1 gives 8, 2 gives 16 and 3 gives 32. Pages are aligned to their own length. Two addresses share a page when they agree above bit 1+cfg_page_sz.
- R3: A read that does not hit the open page holds mem_rd_n low for cfg_first_cyc cycles, with 0 counted as 1. mem_cs_n is low on every cycle where mem_rd_n is low.
- R4: When cfg_page_en is 1, a read that hits the page of the previous completed read holds mem_rd_n low for cfg_next_cyc cycles, with 0 counted as 1.
- R5: When cfg_page_en is 0, every read uses the first-access time and mem_cs_n returns high once each read completes.
- R6: When cfg_page_en is 1, mem_cs_n stays low while idle after a read. A read to another page first spends exactly one cycle with mem_cs_n and mem_rd_n both high before its strobe starts.
- R7: The remembered page is forgotten on reset, whenever cfg_page_en is 0, and whenever cfg_page_sz changes. The next read then uses the first-access time.
- R8: During a strobe, mem_addr carries the accepted address. Bit 0 is forced to 0 when cfg_bus16 is 1. When cfg_bus16 is 0 only mem_din[7:0] is returned and rsp_data[15:8] is 0.
- R9: rsp_data holds mem_din as sampled on the last low cycle of mem_rd_n. rsp_ack is 1 for exactly the one cycle after the strobe ends.
- R10: From the cycle after a request is accepted until the acknowledge cycle, req_ready is 0. Requests offered in that window are ignored and do not alter mem_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_en | input | 1 | 1 enables in-page short reads |
| cfg_page_sz | input | 2 | Page length code (0:4, 1:8, 2:16, 3:32 bytes) |
| cfg_bus16 | input | 1 | 1 for a 16-bit device, 0 for 8-bit |
| cfg_first_cyc | input | 6 | Strobe cycles for a page-opening read |
| cfg_next_cyc | input | 6 | Strobe cycles for an in-page read |
| req_valid | input | 1 | Read request |
| req_addr | input | 24 | Byte address of the request |
| req_ready | output | 1 | Sequencer can take a request |
| rsp_ack | output | 1 | One-cycle pulse, rsp_data valid |
| rsp_data | output | 16 | Read data |
| mem_addr | output | 24 | External address bus |
| mem_cs_n | output | 1 | External chip select, active low |
| mem_rd_n | output | 1 | External read strobe, active low |
| mem_din | input | 16 | External data bus |

## Verification
Random addresses drawn from a narrow window produce long runs of in-page hits broken by page changes. Comparing the measured strobe length against the two programmed times therefore separates a correct page compare from one that uses the wrong boundary bit. Random page-size codes, both device widths and occasional disabled page mode show whether the remembered page is dropped and whether the one-cycle gap appears only on a real page change. Directed cases cover zero and maximum timing values, a size change between two reads of the same address, and requests held high while the sequencer is busy.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GAP    = 2'd1,
    ST_STROBE = 2'd2
  } seq_state_t;

  // bit index of the lowest page-number bit for a size code
  function automatic logic [2:0] page_lsb(input logic [1:0] sz);
    return 3'd2 + {1'b0, sz};
  endfunction

  // true when two byte addresses lie in the same page
  function automatic logic in_same_page(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [1:0]  sz);
    return (a >> page_lsb(sz)) == (b >> page_lsb(sz));
  endfunction

endpackage

// File: rtl/pgrd_page_track.sv
module pgrd_page_track #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_en,
  input  logic [1:0]        page_sz,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              upd,
  input  logic [ADDR_W-1:0] upd_addr,
  output logic              open,
  output logic              hit
);
  import pgrd_pkg::*;

  logic [ADDR_W-1:0] tag_q;
  logic              valid_q;
  logic [1:0]        sz_q;
  logic              sz_moved;

  assign sz_moved = (page_sz != sz_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      sz_q    <= '0;
    end else begin
      sz_q <= page_sz;
      if (!page_en || sz_moved) begin
        valid_q <= 1'b0;
      end else if (upd) begin
        valid_q <= 1'b1;
        tag_q   <= upd_addr;
      end
    end
  end

  assign open = page_en && valid_q && !sz_moved;
  assign hit  = open && in_same_page(32'(probe_addr), 32'(tag_q), page_sz);

endmodule

// File: rtl/pgrd_strobe_timer.sv
module pgrd_strobe_timer #(
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic              last
);
  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] eff_val;

  // a programmed zero behaves as a single cycle
  assign eff_val = (load_val == '0) ? TIME_W'(1) : load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TIME_W'(1);
    end else if (load) begin
      cnt_q <= eff_val;
    end else if (cnt_q > TIME_W'(1)) begin
      cnt_q <= cnt_q - TIME_W'(1);
    end
  end

  assign last = (cnt_q == TIME_W'(1));

endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_page_en,
  input  logic [1:0]        cfg_page_sz,
  input  logic              cfg_bus16,
  input  logic [TIME_W-1:0] cfg_first_cyc,
  input  logic [TIME_W-1:0] cfg_next_cyc,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  input  logic [DATA_W-1:0] mem_din
);
  import pgrd_pkg::*;

  localparam int LO_W = DATA_W / 2;

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              use_first_q;
  logic              accept;
  logic              page_open;
  logic              page_hit;
  logic              strobe_last;
  logic              strobe_end;
  logic              gap_now;
  logic              strobe_first;
  logic              tmr_load;
  logic [TIME_W-1:0] tmr_val;

  assign accept     = req_valid && (state_q == ST_IDLE);
  assign strobe_end = (state_q == ST_STROBE) && strobe_last;

  pgrd_page_track #(.ADDR_W(ADDR_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_en    (cfg_page_en),
    .page_sz    (cfg_page_sz),
    .probe_addr (req_addr),
    .upd        (strobe_end),
    .upd_addr   (addr_q),
    .open       (page_open),
    .hit        (page_hit)
  );

  pgrd_strobe_timer #(.TIME_W(TIME_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (strobe_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = cfg_first_cyc;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (page_hit) begin
            state_d  = ST_STROBE;
            tmr_load = 1'b1;
            tmr_val  = cfg_next_cyc;
          end else if (page_open) begin
            state_d  = ST_GAP;
          end else begin
            state_d  = ST_STROBE;
            tmr_load = 1'b1;
          end
        end
      end
      ST_GAP: begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
      end
      ST_STROBE: begin
        if (strobe_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      use_first_q <= 1'b1;
      rsp_ack     <= 1'b0;
      rsp_data    <= '0;
    end else begin
      state_q <= state_d;
      rsp_ack <= strobe_end;
      if (accept) begin
        addr_q      <= req_addr;
        use_first_q <= !page_hit;
      end
      if (strobe_end) begin
        rsp_data <= cfg_bus16 ? mem_din
                              : {{(DATA_W-LO_W){1'b0}}, mem_din[LO_W-1:0]};
      end
    end
  end

  assign gap_now      = (state_q == ST_GAP);
  assign strobe_first = use_first_q;

  assign req_ready = (state_q == ST_IDLE);
  assign mem_rd_n  = (state_q != ST_STROBE);
  assign mem_cs_n  = !((state_q == ST_STROBE) || ((state_q == ST_IDLE) && page_open));
  assign mem_addr  = {addr_q[ADDR_W-1:1], addr_q[0] & !cfg_bus16};

endmodule

// File: rtl/pgrd_seq_chk.sv
module pgrd_seq_chk #(
  parameter int TIME_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_page_en,
  input logic              cfg_bus16,
  input logic [TIME_W-1:0] cfg_first_cyc,
  input logic [TIME_W-1:0] cfg_next_cyc,
  input logic              req_ready,
  input logic              rsp_ack,
  input logic              mem_cs_n,
  input logic              mem_rd_n,
  input logic              mem_addr0,
  input logic              gap_now,
  input logic              page_hit,
  input logic              strobe_first
);
  logic [TIME_W:0] run_q;
  logic [TIME_W:0] exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (!mem_rd_n) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  always_comb begin
    if (strobe_first) exp_len = (cfg_first_cyc == '0) ? 1 : {1'b0, cfg_first_cyc};
    else              exp_len = (cfg_next_cyc  == '0) ? 1 : {1'b0, cfg_next_cyc};
  end

  AST_RD_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> !mem_cs_n); // R3

  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> (run_q == exp_len)); // R4

  AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_page_en |-> !page_hit); // R5

  AST_GAP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_now |-> (mem_cs_n && mem_rd_n && $past(!mem_cs_n))); // R6

  AST_GAP_THEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    gap_now |=> (!mem_rd_n && strobe_first)); // R6

  AST_ADDR_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && cfg_bus16) |-> !mem_addr0); // R8

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack); // R9

  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> (mem_rd_n && $past(!mem_rd_n))); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || gap_now) |-> !req_ready); // R10

endmodule

bind pgrd_seq pgrd_seq_chk #(.TIME_W(TIME_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_page_en   (cfg_page_en),
  .cfg_bus16     (cfg_bus16),
  .cfg_first_cyc (cfg_first_cyc),
  .cfg_next_cyc  (cfg_next_cyc),
  .req_ready     (req_ready),
  .rsp_ack       (rsp_ack),
  .mem_cs_n      (mem_cs_n),
  .mem_rd_n      (mem_rd_n),
  .mem_addr0     (mem_addr[0]),
  .gap_now       (gap_now),
  .page_hit      (page_hit),
  .strobe_first  (strobe_first)
);

// File: tb/tb_pgrd_seq.sv
module tb_pgrd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_page_en = 1'b0;
  logic [1:0]  cfg_page_sz = 2'd0;
  logic        cfg_bus16 = 1'b0;
  logic [5:0]  cfg_first_cyc = 6'd3;
  logic [5:0]  cfg_next_cyc = 6'd1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_ready, rsp_ack, mem_cs_n, mem_rd_n;
  logic [15:0] rsp_data, mem_din;
  logic [23:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state of the remembered page
  bit          m_valid = 0;
  logic [23:0] m_page = '0;

  always #4 clk = ~clk;

  function automatic logic [15:0] pat(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + a[23:16] + 8'h3C};
  endfunction

  assign mem_din = pat(mem_addr);

  pgrd_seq dut (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [5:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic set_cfg(input bit en, input logic [1:0] sz, input bit b16,
                         input logic [5:0] f, input logic [5:0] n);
    @(negedge clk);
    if (!en || sz != cfg_page_sz) m_valid = 0;   // R7 forget rules
    cfg_page_en = en; cfg_page_sz = sz; cfg_bus16 = b16;
    cfg_first_cyc = f; cfg_next_cyc = n;
    @(negedge clk);
    chk(mem_cs_n == !(en && m_valid), "R7", "idle cs_n after cfg", mem_cs_n, !(en && m_valid));
  endtask

  task automatic do_read(input logic [23:0] a);
    int sh, strobe, gap, guard, exp_len, exp_gap;
    bit hit, addr_ok, rdy_ok;
    logic [23:0] ea;
    logic [15:0] ed;
    sh  = 2 + int'(cfg_page_sz);
    hit = cfg_page_en && m_valid && ((a >> sh) == (m_page >> sh));
    exp_gap = (cfg_page_en && m_valid && !hit) ? 1 : 0;
    exp_len = hit ? eff(cfg_next_cyc) : eff(cfg_first_cyc);
    ea = cfg_bus16 ? {a[23:1], 1'b0} : a;
    ed = cfg_bus16 ? pat(ea) : {8'h00, pat(ea)[7:0]};
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_addr = ~a;                                 // R10 junk held while busy
    strobe = 0; gap = 0; guard = 0; addr_ok = 1; rdy_ok = 1;
    while (!rsp_ack && guard < 200) begin
      if (req_ready) rdy_ok = 0;
      if (!mem_rd_n) begin
        strobe++;
        if (mem_addr != ea) addr_ok = 0;
      end else if (mem_cs_n) gap++;
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    chk(rsp_ack == 1'b1, "R9", "ack seen", rsp_ack, 1);
    chk(rsp_data == ed, "R9", "rsp_data", rsp_data, ed);
    if (hit) chk(strobe == exp_len, "R4", "in-page strobe len", strobe, exp_len);
    else     chk(strobe == exp_len, "R3", "first strobe len", strobe, exp_len);
    chk(gap == exp_gap, "R6", "gap cycles", gap, exp_gap);
    chk(addr_ok, "R8", "mem_addr during strobe", mem_addr, ea);
    chk(rdy_ok, "R10", "ready low while busy", 0, 0);
    if (cfg_page_en) begin m_valid = 1; m_page = a; end
    @(negedge clk);
    chk(rsp_ack == 1'b0, "R9", "ack single pulse", rsp_ack, 0);
    if (cfg_page_en) chk(mem_cs_n == 1'b0, "R6", "cs held idle", mem_cs_n, 0);
    else             chk(mem_cs_n == 1'b1, "R5", "cs released idle", mem_cs_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && mem_cs_n == 1 && mem_rd_n == 1 && rsp_ack == 0,
        "R1", "reset outputs", {req_ready, mem_cs_n, mem_rd_n, rsp_ack}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1 && mem_cs_n == 1, "R1", "after release", {req_ready, mem_cs_n}, 2'b11);

    // R5 page mode off: first timing every time
    set_cfg(0, 2'd1, 0, 6'd4, 6'd1);
    do_read(24'h000010); do_read(24'h000011);
    // R2 size 8 bytes: 0x10..0x17 share a page, 0x18 does not
    set_cfg(1, 2'd1, 1, 6'd5, 6'd2);
    do_read(24'h000010); do_read(24'h000017); do_read(24'h000018); do_read(24'h00001F);
    // R3 R4 zero timing counted as one, maximum first timing
    set_cfg(1, 2'd3, 0, 6'd0, 6'd0);
    do_read(24'h000100); do_read(24'h00011F);
    set_cfg(1, 2'd3, 0, 6'd63, 6'd0);
    do_read(24'h000120); do_read(24'h00013E);
    // R7 size change forgets the page
    set_cfg(1, 2'd2, 0, 6'd3, 6'd1);
    do_read(24'h000200);
    set_cfg(1, 2'd3, 0, 6'd3, 6'd1);
    do_read(24'h000201);
    // R7 disable then re-enable forgets the page
    set_cfg(0, 2'd3, 0, 6'd3, 6'd1);
    set_cfg(1, 2'd3, 0, 6'd3, 6'd1);
    do_read(24'h000202);
    // R8 odd address on a 16-bit device
    set_cfg(1, 2'd0, 1, 6'd2, 6'd1);
    do_read(24'h00ABC3);

    // constrained random phase, fixed seed
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 16 == 0)
        set_cfg(($urandom % 4) != 0, 2'($urandom % 4), 1'($urandom % 2),
                6'($urandom % 10), 6'($urandom % 6));
      if ($urandom % 8 == 0) do_read(24'($urandom));
      else                   do_read(24'h004000 + 24'($urandom % 96));
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule